// File: doc/BRIEF.md
# Runtime-Configurable Forward Number Theoretic Transform Engine

This block computes a forward number theoretic transform in place over a coefficient store of its own. The job length and the prime modulus are chosen per job. The host fills the store through a one-word-per-cycle port, with the input already in bit-reversed order. It then presents the modulus, the modulus bit width, a Barrett constant and a primitive root of unity of the job's order, and pulses `start`. The engine runs every radix-2 decimation-in-time stage in turn, with the butterfly span doubling each stage. It then pulses `done`, and the host reads the transformed words back through the same port.

The stage twiddle factors are not stored. At the start of each stage the engine squares the supplied root repeatedly to obtain the stage root. Within each butterfly group, the running twiddle advances by one modular multiply per butterfly. One Barrett multiplier serves the butterfly product, the twiddle step and the squaring. Each butterfly takes five cycles on a single-port store.

Top module: `nttEngine`

## Requirements
- R1: While and right after `rst` is high, `busy` and `done` are low.
- R2: `lenSel` picks the length n = 256 << lenSel (0:256, 1:512, 2:1024, 3:2048). The host writes input a_i at address bitrev_log2(n)(i). After the job, address k holds (sum over i of a_i·ω^(i·k)) mod q, where ω is `rootN`. Addresses from n upward are not touched.
- R3: Any prime q from 13 to 32 bits is accepted, provided `qWidth` is its bit length and `barrettK` = floor(2^(2·qWidth)/q). `modQ`, `qWidth`, `barrettK`, `rootN` and `lenSel` are sampled only on the edge that accepts `start`.
- R4: Every word the engine writes into the store lies in [0, q).
- R5: `start` is ignored while `busy` is high. A second pulse during a job, even with different configuration inputs, leaves the job's result and timing unchanged.
- R6: `done` is high for exactly one cycle, the cycle in which `busy` has just dropped after the last write of the final stage.
- R7: With L = log2(n), `done` rises exactly 2L + L(L−1)/2 + 5·L·n/2 clock edges after the edge that accepts `start`.
- R8: While idle, `hostWe` writes `hostWrData` to `hostAddr`, and `hostRdData` shows the word at `hostAddr` one cycle after the address is presented. Host writes while `busy` is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job when idle |
| lenSel | input | 2 | Length code, n = 256 << lenSel |
| modQ | input | 32 | Prime modulus q |
| qWidth | input | 6 | Bit length of q |
| barrettK | input | 33 | floor(2^(2·qWidth)/q) |
| rootN | input | 32 | Primitive n-th root of unity mod q |
| hostWe | input | 1 | Host write strobe, honoured only when idle |
| hostAddr | input | 11 | Host word address |
| hostWrData | input | 32 | Host write word |
| hostRdData | output | 32 | Word read from the store, one cycle after the address |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches four things on every cycle. Every engine write stays below the modulus latched at start. `done` lasts exactly one cycle and always closes a busy period. A busy period can only begin after `start`. Reset clears both status outputs. Only the bench's jobs can show the transform values themselves, the exact latency per length, and the effect of a second start or host write during a job. Those jobs compare every read-back word against a direct O(n²) evaluation of the sum, across six primes and all four lengths.

// File: rtl/nttPkg.sv
package nttPkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 11;
  localparam int K_W     = DATA_W + 1;
  localparam int WID_W   = 6;
  localparam int LSEL_W  = 2;
  localparam int MIN_LOG = 8;
  localparam int LOG_W   = $clog2(ADDR_W + 1);
  localparam int DEPTH   = 1 << ADDR_W;

  // Strobes from the sequencer to the arithmetic side.
  typedef struct packed {
    logic cfgLoad;
    logic stageLoad;
    logic stageSquare;
    logic captureHi;
    logic captureU;
    logic loadT;
    logic twStep;
    logic twReset;
    logic wrUpper;
  } nttStrobes_t;

  // Barrett product a*b mod q; w is the bit length of q, k = floor(2^(2w)/q).
  function automatic logic [DATA_W-1:0] mulMod(
      input logic [DATA_W-1:0] a,
      input logic [DATA_W-1:0] b,
      input logic [DATA_W-1:0] q,
      input logic [K_W-1:0]    k,
      input logic [WID_W-1:0]  w);
    logic [2*DATA_W-1:0] p;
    logic [DATA_W:0]     x;
    logic [2*DATA_W+1:0] e;
    logic [DATA_W:0]     qh;
    logic [2*DATA_W+1:0] qq;
    logic [DATA_W+2:0]   r;
    logic [DATA_W+2:0]   qx;
    p  = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    x  = (DATA_W+1)'(p >> (w - 6'd1));
    e  = (2*DATA_W+2)'(x) * (2*DATA_W+2)'(k);
    qh = (DATA_W+1)'(e >> (w + 6'd1));
    qq = (2*DATA_W+2)'(qh) * (2*DATA_W+2)'(q);
    r  = (DATA_W+3)'((2*DATA_W+2)'(p) - qq);
    qx = (DATA_W+3)'(q);
    if (r >= qx) r = r - qx;
    if (r >= qx) r = r - qx;
    return r[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] addMod(
      input logic [DATA_W-1:0] u, input logic [DATA_W-1:0] t,
      input logic [DATA_W-1:0] q);
    logic [DATA_W:0] s;
    s = {1'b0, u} + {1'b0, t};
    if (s >= {1'b0, q}) s = s - {1'b0, q};
    return s[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] subMod(
      input logic [DATA_W-1:0] u, input logic [DATA_W-1:0] t,
      input logic [DATA_W-1:0] q);
    return (u >= t) ? (u - t) : (u + (q - t));
  endfunction
endpackage

// File: rtl/coefRam.sv
module coefRam
  import nttPkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wrData;
    rdData <= mem[addr];
  end
endmodule

// File: rtl/nttCtrl.sv
module nttCtrl
  import nttPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LSEL_W-1:0] lenSel,
  output nttStrobes_t       stb,
  output logic [ADDR_W-1:0] coreAddr,
  output logic              coreWe,
  output logic              busy,
  output logic              done
);
  typedef enum logic [2:0] {
    S_IDLE, S_STAGE, S_SQ, S_RDHI, S_RDLO, S_MUL, S_WRLO, S_WRHI
  } state_t;

  state_t            state;
  logic [LOG_W-1:0]  logLen, stageIdx, sqCnt;
  logic [ADDR_W:0]   kBase;
  logic [ADDR_W-1:0] jIdx;
  logic              doneReg;

  logic [ADDR_W:0] spanM, loIdx, hiIdx, lenN;
  logic            lastJ, lastGroup, lastStage;

  always_comb begin
    spanM     = (ADDR_W+1)'(1) << stageIdx;
    lenN      = (ADDR_W+1)'(1) << logLen;
    loIdx     = kBase + {1'b0, jIdx};
    hiIdx     = loIdx + spanM;
    lastJ     = ({1'b0, jIdx} == spanM - 1'b1);
    lastGroup = (kBase + (spanM << 1) == lenN);
    lastStage = (stageIdx == logLen - 1'b1);
  end

  always_comb begin
    stb = '0;
    unique case (state)
      S_IDLE:  stb.cfgLoad     = start;
      S_STAGE: stb.stageLoad   = 1'b1;
      S_SQ:    stb.stageSquare = (sqCnt != '0);
      S_RDLO:  stb.captureHi   = 1'b1;
      S_MUL: begin
        stb.captureU = 1'b1;
        stb.loadT    = 1'b1;
      end
      S_WRLO:  stb.twStep      = 1'b1;
      S_WRHI: begin
        stb.wrUpper = 1'b1;
        stb.twReset = lastJ;
      end
      default: ;
    endcase
  end

  assign coreAddr = (state == S_RDHI || state == S_WRHI) ? hiIdx[ADDR_W-1:0]
                                                          : loIdx[ADDR_W-1:0];
  assign coreWe   = (state == S_WRLO) || (state == S_WRHI);
  assign busy     = (state != S_IDLE);
  assign done     = doneReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      logLen   <= '0;
      stageIdx <= '0;
      sqCnt    <= '0;
      kBase    <= '0;
      jIdx     <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          logLen   <= LOG_W'(MIN_LOG) + LOG_W'(lenSel);
          stageIdx <= '0;
          state    <= S_STAGE;
        end
        S_STAGE: begin
          sqCnt <= logLen - 1'b1 - stageIdx;
          kBase <= '0;
          jIdx  <= '0;
          state <= S_SQ;
        end
        S_SQ: begin
          if (sqCnt == '0) state <= S_RDHI;
          else             sqCnt <= sqCnt - 1'b1;
        end
        S_RDHI: state <= S_RDLO;
        S_RDLO: state <= S_MUL;
        S_MUL:  state <= S_WRLO;
        S_WRLO: state <= S_WRHI;
        S_WRHI: begin
          if (!lastJ) begin
            jIdx  <= jIdx + 1'b1;
            state <= S_RDHI;
          end else begin
            jIdx <= '0;
            if (!lastGroup) begin
              kBase <= kBase + (spanM << 1);
              state <= S_RDHI;
            end else if (!lastStage) begin
              stageIdx <= stageIdx + 1'b1;
              state    <= S_STAGE;
            end else begin
              state   <= S_IDLE;
              doneReg <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nttDatapath.sv
module nttDatapath
  import nttPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  nttStrobes_t       stb,
  input  logic [DATA_W-1:0] modQ,
  input  logic [WID_W-1:0]  qWidth,
  input  logic [K_W-1:0]    barrettK,
  input  logic [DATA_W-1:0] rootN,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] coreWrData
);
  logic [DATA_W-1:0] qReg, rootReg, hiReg, uReg, tReg, twReg, stReg;
  logic [K_W-1:0]    kReg;
  logic [WID_W-1:0]  wReg;
  logic [DATA_W-1:0] opA, opB, prodMod, sumVal, diffVal;

  always_comb begin
    if (stb.loadT) begin
      opA = hiReg;
      opB = twReg;
    end else if (stb.twStep) begin
      opA = twReg;
      opB = stReg;
    end else begin
      opA = stReg;
      opB = stReg;
    end
    prodMod    = mulMod(opA, opB, qReg, kReg, wReg);
    sumVal     = addMod(uReg, tReg, qReg);
    diffVal    = subMod(uReg, tReg, qReg);
    coreWrData = stb.wrUpper ? diffVal : sumVal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qReg    <= DATA_W'(1);
      kReg    <= '0;
      wReg    <= WID_W'(1);
      rootReg <= '0;
      hiReg   <= '0;
      uReg    <= '0;
      tReg    <= '0;
      twReg   <= '0;
      stReg   <= '0;
    end else begin
      if (stb.cfgLoad) begin
        qReg    <= modQ;
        kReg    <= barrettK;
        wReg    <= qWidth;
        rootReg <= rootN;
      end
      if (stb.stageLoad) begin
        stReg <= rootReg;
        twReg <= DATA_W'(1);
      end
      if (stb.stageSquare) stReg <= prodMod;
      if (stb.captureHi)   hiReg <= ramRdData;
      if (stb.captureU)    uReg  <= ramRdData;
      if (stb.loadT)       tReg  <= prodMod;
      if (stb.twStep)      twReg <= prodMod;
      if (stb.twReset)     twReg <= DATA_W'(1);
    end
  end
endmodule

// File: rtl/nttEngine.sv
module nttEngine
  import nttPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LSEL_W-1:0] lenSel,
  input  logic [DATA_W-1:0] modQ,
  input  logic [WID_W-1:0]  qWidth,
  input  logic [K_W-1:0]    barrettK,
  input  logic [DATA_W-1:0] rootN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              busy,
  output logic              done
);
  nttStrobes_t       stb;
  logic [ADDR_W-1:0] coreAddr, ramAddr;
  logic              coreWe, ramWe;
  logic [DATA_W-1:0] coreWrData, ramWrData, ramRdData;

  nttCtrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .lenSel(lenSel), .stb(stb),
    .coreAddr(coreAddr), .coreWe(coreWe), .busy(busy), .done(done)
  );

  nttDatapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .modQ(modQ), .qWidth(qWidth),
    .barrettK(barrettK), .rootN(rootN), .ramRdData(ramRdData),
    .coreWrData(coreWrData)
  );

  assign ramAddr   = busy ? coreAddr   : hostAddr;
  assign ramWe     = busy ? coreWe     : hostWe;
  assign ramWrData = busy ? coreWrData : hostWrData;

  coefRam u_ram (
    .clk(clk), .we(ramWe), .addr(ramAddr), .wrData(ramWrData),
    .rdData(ramRdData)
  );

  assign hostRdData = ramRdData;
endmodule

// File: rtl/nttEngineChk.sv
module nttEngineChk
  import nttPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              ramWe,
  input logic [DATA_W-1:0] ramWrData,
  input logic [DATA_W-1:0] modQ
);
  logic [DATA_W-1:0] qHeld;

  always_ff @(posedge clk) begin
    if (rst)                qHeld <= '1;
    else if (start && !busy) qHeld <= modQ;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done));

  p_write_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && ramWe) |-> (ramWrData < qHeld));

  p_busy_needs_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind nttEngine nttEngineChk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ramWe(ramWe), .ramWrData(ramWrData), .modQ(modQ)
);

// File: tb/sim_nttEngine.sv
module sim_nttEngine;
  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 2048;

  logic        clk = 1'b0;
  logic        rst, start, hostWe;
  logic [1:0]  lenSel;
  logic [31:0] modQ, rootN, hostWrData, hostRdData;
  logic [5:0]  qWidth;
  logic [32:0] barrettK;
  logic [10:0] hostAddr;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;

  longint unsigned coef [MAXN];

  always #(CLK_PERIOD/2) clk = ~clk;

  nttEngine u0 (
    .clk(clk), .rst(rst), .start(start), .lenSel(lenSel), .modQ(modQ),
    .qWidth(qWidth), .barrettK(barrettK), .rootN(rootN), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .busy(busy), .done(done)
  );

  function automatic longint unsigned powMod(longint unsigned b, longint unsigned e,
                                             longint unsigned q);
    longint unsigned r = 1;
    longint unsigned x = b % q;
    while (e != 0) begin
      if (e[0]) r = (r * x) % q;
      x = (x * x) % q;
      e = e >> 1;
    end
    return r;
  endfunction

  function automatic int bitRev(int v, int bits);
    int r = 0;
    for (int i = 0; i < bits; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp,
                       string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runJob(int sel, longint unsigned q, bit intrude);
    int L = 8 + sel;
    int n = 1 << L;
    int w = 0;
    longint unsigned root = 0;
    logic [65:0] kWide;
    int expCyc = 2*L + L*(L-1)/2 + 5*L*(n/2);
    int cnt = 0;
    bit seen = 0;
    longint unsigned acc, pw, wk, got;
    int errs = 0;

    while ((q >> w) != 0) w++;
    kWide = (66'd1 << (2*w)) / 66'(q);
    for (longint unsigned x = 2; x < q; x++) begin
      root = powMod(x, (q - 1) / n, q);
      if (powMod(root, n / 2, q) != 1) break;
    end
    for (int i = 0; i < n; i++) begin
      if (i == 0)      coef[i] = q - 1;
      else if (i == 1) coef[i] = 0;
      else             coef[i] = (longint'(i) * 40503 + 977 * sel + q / 3) % q;
    end

    // R8: load in bit-reversed order while idle
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = 11'(bitRev(i, L)); hostWrData = 32'(coef[i]);
    end
    @(negedge clk);
    hostWe = 1'b0;
    lenSel = 2'(sel); modQ = 32'(q); qWidth = 6'(w);
    barrettK = 33'(kWide); rootN = 32'(root);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", busy, 1, "busy after start");
    while (!seen && cnt < 100000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (intrude && cnt == 100) begin
        // R5/R8: second start with other settings plus a host write, both while busy
        start = 1'b1; lenSel = 2'd3; modQ = 32'd7681; rootN = 32'd17;
        hostWe = 1'b1; hostAddr = 11'd0; hostWrData = 32'd5;
      end
      if (intrude && cnt == 101) begin
        start = 1'b0; hostWe = 1'b0;
      end
      if (done) seen = 1;
    end
    check(cnt == expCyc, "R7", cnt, expCyc, "start-to-done edges");
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6", done, 0, "done one cycle");

    for (int k = 0; k < n; k++) begin
      hostAddr = 11'(k);
      @(negedge clk);
      got = hostRdData;
      acc = 0; pw = 1; wk = powMod(root, k, q);
      for (int i = 0; i < n; i++) begin
        acc = (acc + coef[i] * pw) % q;
        pw  = (pw * wk) % q;
      end
      check(got < q, "R4", got, q - 1, "coefficient range");
      check(got == acc, intrude ? "R5" : "R3", got, acc, "transform coefficient (R2)");
      if (got != acc) errs++;
    end
    if (sel < 3) begin
      // R2: address n lies outside the job and must keep its sentinel
      hostAddr = 11'(n);
      @(negedge clk);
      check(hostRdData == 32'hA5A5_0000 + 32'(sel), "R2", hostRdData,
            32'hA5A5_0000 + 32'(sel), "word above n untouched");
    end
    $display("job n=%0d q=%0d errors=%0d", n, q, errs);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; hostWe = 1'b0; lenSel = '0; modQ = 32'd7681;
    qWidth = 6'd13; barrettK = '0; rootN = '0; hostAddr = '0; hostWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R1", busy, 0, "busy in reset");
    check(done == 1'b0, "R1", done, 0, "done in reset");
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1", busy, 0, "idle after reset");

    // sentinels above each smaller length (R2)
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = 11'(256 << s); hostWrData = 32'hA5A5_0000 + 32'(s);
    end
    @(negedge clk);
    hostWe = 1'b0;

    // R8: plain write/read through the host port
    hostWe = 1'b1; hostAddr = 11'd2047; hostWrData = 32'hDEAD_BEEF;
    @(negedge clk);
    hostWe = 1'b0;
    @(negedge clk);
    check(hostRdData == 32'hDEAD_BEEF, "R8", hostRdData, 32'hDEAD_BEEF, "host readback");

    runJob(0, 64'd7681, 1'b0);
    runJob(0, 64'd12289, 1'b0);
    runJob(0, 64'd998244353, 1'b1);
    runJob(0, 64'd2013265921, 1'b0);
    runJob(1, 64'd65537, 1'b0);
    runJob(2, 64'd786433, 1'b0);
    runJob(3, 64'd12289, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule